// File: doc/BRIEF.md
# Three-Source Fused Integer ALU

This block is a 32-bit integer datapath that takes three source operands and a 9-bit opcode. It performs one of six fused operations, each a shift, XOR, sum or narrow multiply followed by an add. The six operations are a three-way sum, a sum followed by a left shift, a left shift followed by an add, an XOR followed by an add, and an unsigned or signed 16x16 multiply with a full-width addend. Every result wraps modulo 2^32, and no carry or overflow flag is produced.

A valid bit travels alongside the operands. Any opcode outside the supported six yields a zero result and raises an illegal flag for that transaction. With the default parameters the outputs are registered, so a result appears one clock after the operands are presented. A new transaction can be accepted on every clock.

Top module: `tri_src_alu`

## Requirements
- R1: Opcode 511 returns src_a + src_b + src_c modulo 2^32. For example, three operands of 0xFFFFFFFF give 0xFFFFFFFD.
- R2: Opcode 510 returns (src_a + src_b) modulo 2^32, shifted left by src_c[4:0]. Bits 31:5 of src_c have no effect, so src_c = 32 shifts by zero.
- R3: Opcode 509 returns (src_a shifted left by src_b[4:0]) + src_c modulo 2^32. Bits 31:5 of src_b have no effect.
- R4: Opcode 499 returns (src_a XOR src_b) + src_c modulo 2^32.
- R5: Opcode 497 returns src_a[15:0] * src_b[15:0] + src_c modulo 2^32, with both factors unsigned. The upper halves of src_a and src_b have no effect.
- R6: Opcode 498 returns sext(src_a[15:0]) * sext(src_b[15:0]) + src_c modulo 2^32, with both factors taken as two's-complement values. For example, -32768 * -32768 gives 0x40000000.
- R7: Any other opcode value, valid alongside in_valid, gives out_result = 0 and out_illegal = 1 in the output cycle of that transaction.
- R8: After reset, out_valid, out_illegal and out_result are all 0. out_valid equals in_valid delayed by one clock.
- R9: When in_valid is low, out_result keeps its previous value and out_illegal is 0 in the following cycle, whatever the opcode input holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| opcode | input | 9 | Operation select |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| src_c | input | 32 | Third source operand |
| out_valid | output | 1 | Result is valid |
| out_illegal | output | 1 | The transaction carried an unsupported opcode |
| out_result | output | 32 | Operation result |

## Verification
The output register can present the result of one transaction while the next transaction, legal or illegal, is being accepted at the input in the same cycle. The bench provokes this with back-to-back streams that mix all six opcodes with illegal ones, and it interleaves idle cycles that carry illegal opcode values. A behavioural model advanced once per clock gives the expected valid, illegal and result values. The bench compares them on every cycle, so a flag or result that leaks from one transaction into its neighbour is reported against the transaction that owns it.

// File: rtl/tri_src_alu.sv
module tri_src_alu #(
  parameter int DATA_W  = 32,
  parameter int OPC_W   = 9,
  parameter int MUL_W   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] src_c,
  output logic              out_valid,
  output logic              out_illegal,
  output logic [DATA_W-1:0] out_result
);
  localparam int SH_W = $clog2(DATA_W);
  localparam logic [OPC_W-1:0] OP_MAD_U = OPC_W'(497);
  localparam logic [OPC_W-1:0] OP_MAD_S = OPC_W'(498);
  localparam logic [OPC_W-1:0] OP_XADD  = OPC_W'(499);
  localparam logic [OPC_W-1:0] OP_SHADD = OPC_W'(509);
  localparam logic [OPC_W-1:0] OP_ADDSH = OPC_W'(510);
  localparam logic [OPC_W-1:0] OP_ADD3  = OPC_W'(511);

  logic [DATA_W-1:0]         sum_ab;
  logic [2*MUL_W-1:0]        uprod;
  logic signed [2*MUL_W-1:0] sprod;
  logic [DATA_W-1:0]         res;
  logic                      legal;

  assign sum_ab = src_a + src_b;
  assign uprod  = src_a[MUL_W-1:0] * src_b[MUL_W-1:0];
  assign sprod  = $signed(src_a[MUL_W-1:0]) * $signed(src_b[MUL_W-1:0]);

  always_comb begin
    legal = 1'b1;
    res   = '0;
    case (opcode)
      OP_ADD3:  res = sum_ab + src_c;
      OP_ADDSH: res = sum_ab << src_c[SH_W-1:0];
      OP_SHADD: res = (src_a << src_b[SH_W-1:0]) + src_c;
      OP_XADD:  res = (src_a ^ src_b) + src_c;
      OP_MAD_U: res = DATA_W'(uprod) + src_c;
      OP_MAD_S: res = DATA_W'(sprod) + src_c;
      default:  legal = 1'b0;
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          out_valid   <= 1'b0;
          out_illegal <= 1'b0;
          out_result  <= '0;
        end else begin
          out_valid   <= in_valid;
          out_illegal <= in_valid & ~legal;
          if (in_valid) out_result <= res;
        end
      end
    end else begin : g_comb
      assign out_valid   = in_valid;
      assign out_illegal = in_valid & ~legal;
      assign out_result  = res;
    end
  endgenerate
endmodule

module tri_src_alu_chk #(
  parameter int DATA_W  = 32,
  parameter int OPC_W   = 9,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [OPC_W-1:0]  opcode,
  input logic              out_valid,
  input logic              out_illegal,
  input logic [DATA_W-1:0] out_result
);
  assert_illegal_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (out_valid && out_result == '0));

  generate
    if (REG_OUT) begin : g_seq
      logic seen_rst;
      always_ff @(posedge clk) seen_rst <= !rst_n ? 1'b1 : seen_rst;

      assert_valid_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst && $past(rst_n)) |-> (out_valid == $past(in_valid)));

      assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst && $past(rst_n) && !$past(in_valid)) |-> ($stable(out_result) && !out_illegal));

      assert_legal_no_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst && $past(rst_n) && $past(in_valid) && $past(opcode) == OPC_W'(511)) |-> !out_illegal);

      assert_illegal_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst && $past(rst_n) && $past(in_valid) && $past(opcode) < OPC_W'(497)) |-> out_illegal);
    end
  endgenerate
endmodule

bind tri_src_alu tri_src_alu_chk #(.DATA_W(DATA_W), .OPC_W(OPC_W), .REG_OUT(REG_OUT)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
  .out_valid(out_valid), .out_illegal(out_illegal), .out_result(out_result)
);

// File: tb/tri_src_alu_tb_top.sv
module tri_src_alu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [8:0]  opcode = '0;
  logic [31:0] src_a = '0, src_b = '0, src_c = '0;
  logic        out_valid, out_illegal;
  logic [31:0] out_result;

  int checks = 0, fails = 0;
  bit exp_valid = 0, exp_ill = 0;
  logic [31:0] exp_res = '0;
  string exp_tag = "R8";

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_src_alu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .src_a(src_a), .src_b(src_b), .src_c(src_c),
    .out_valid(out_valid), .out_illegal(out_illegal), .out_result(out_result)
  );

  function automatic longint s16(logic [31:0] v);
    longint x = longint'(v & 32'hFFFF);
    if (x >= 32768) x -= 65536;
    return x;
  endfunction

  function automatic void model(input logic [8:0] op, input logic [31:0] a, b, c,
                                output logic [31:0] r, output bit ill, output string tag);
    longint m = 64'h1_0000_0000;
    longint la = longint'(a), lb = longint'(b), lc = longint'(c);
    ill = 0; r = 0;
    case (int'(op))
      511: begin tag = "R1"; r = 32'((la + lb + lc) % m); end
      510: begin tag = "R2"; r = 32'((((la + lb) % m) * (64'd1 << (lc % 32))) % m); end
      509: begin tag = "R3"; r = 32'(((la * (64'd1 << (lb % 32))) % m + lc) % m); end
      499: begin tag = "R4"; r = 32'((longint'(a ^ b) + lc) % m); end
      497: begin tag = "R5"; r = 32'(((la % 65536) * (lb % 65536) + lc) % m); end
      498: begin tag = "R6"; r = 32'(((s16(a) * s16(b)) % m + m + lc) % m); end
      default: begin tag = "R7"; ill = 1; end
    endcase
  endfunction

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, logic [8:0] op, logic [31:0] a, b, c);
    logic [31:0] r; bit ill; string tag;
    @(negedge clk);
    check("R8", "out_valid", longint'(out_valid), longint'(exp_valid));
    check(exp_tag, "out_illegal", longint'(out_illegal), longint'(exp_ill));
    check(exp_tag, "out_result", longint'(out_result), longint'(exp_res));
    in_valid = v; opcode = op; src_a = a; src_b = b; src_c = c;
    exp_valid = v;
    if (v) begin
      model(op, a, b, c, r, ill, tag);
      exp_res = r; exp_ill = ill; exp_tag = tag;
    end else begin
      exp_ill = 0; exp_tag = "R9";
    end
  endtask

  function automatic logic [8:0] pick_op(int k);
    case (k % 8)
      0: return 9'd511; 1: return 9'd510; 2: return 9'd509; 3: return 9'd499;
      4: return 9'd497; 5: return 9'd498; default: return 9'($urandom);
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    exp_tag = "R8";
    step(1, 9'd511, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF);
    step(1, 9'd510, 32'h1, 32'h0, 32'd31);
    step(1, 9'd510, 32'h3, 32'h4, 32'd32);
    step(1, 9'd510, 32'h8000_0000, 32'h8000_0001, 32'hFFFF_FFE1);
    step(1, 9'd509, 32'h3, 32'h0000_0FFF, 32'h5);
    step(1, 9'd509, 32'hABCD, 32'd32, 32'h1);
    step(1, 9'd499, 32'hF0F0F0F0, 32'hFFFF0000, 32'h1234_5678);
    step(1, 9'd497, 32'hDEAD_FFFF, 32'hBEEF_FFFF, 32'h2);
    step(1, 9'd498, 32'h0000_8000, 32'hFFFF_8000, 32'h0);
    step(1, 9'd498, 32'h1234_8000, 32'h0000_7FFF, 32'h10);
    step(1, 9'd498, 32'h0000_FFFF, 32'h0000_0001, 32'h0);
    step(1, 9'd0,   32'h1, 32'h2, 32'h3);
    step(1, 9'd496, 32'h1, 32'h2, 32'h3);
    step(1, 9'd511, 32'h1, 32'h2, 32'h3);
    step(0, 9'd5,   32'h9, 32'h9, 32'h9);
    step(0, 9'd511, 32'h9, 32'h9, 32'h9);
    step(1, 9'd500, 32'h7, 32'h7, 32'h7);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] b = $urandom, c = $urandom;
      if (i % 5 == 0) b = (i % 3 == 0) ? 32'd31 : 32'd32;
      if (i % 7 == 0) c = (i % 2 == 0) ? 32'd31 : 32'd32;
      step(($urandom % 5) != 0, pick_op($urandom),
           (i % 11 == 0) ? 32'h0000_8000 : $urandom, b, c);
    end
    step(0, 9'd0, 32'h0, 32'h0, 32'h0);
    step(0, 9'd0, 32'h0, 32'h0, 32'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule